// File: doc/BRIEF.md
# Programmable IRQ Vector Mapper

This block turns eight hardware interrupt request lines into the 8-bit interrupt vector that a CPU core uses to index its handler table. Each request line is captured on its rising edge and stays captured until the CPU takes it. When several captured requests wait at once, the line with the lowest index is offered first. Line 0 is meant for the periodic system timer tick, so the tick always wins against the other lines. The vector is formed by adding the line index to a base offset held in a register. Software loads this register during initialisation. After reset it holds 32.

Vectors 0 to 31 belong to processor exceptions. A base below 32 makes some device vectors share a number with a fault. For example, a base of 8 makes line 5 produce vector 13, the same number as the general-protection fault. The block compares every vector it forms against this reserved range and raises a flag when the vector falls inside it. A global enable hides the pending output without stopping capture. The CPU takes the offered request with a one-cycle acknowledge, and only that request is cleared.

Top module: `irq_vector_mapper`

## Requirements
- R1: After reset the pending and overlap outputs are low and the base register holds 32. A later request on line 0 therefore forms vector 32.
- R2: A request is captured only on a 0-to-1 transition of its line. A line held high after its request has been acknowledged does not raise a new request.
- R3: A captured request stays captured after its line falls, until it is acknowledged.
- R4: When several requests are captured, the vector offered belongs to the lowest-numbered line.
- R5: The offered vector equals (base + winning line index) modulo 256.
- R6: A write strobe loads the base register at the clock edge. Vectors formed from the next cycle on use the new base.
- R7: The overlap flag is high exactly when the pending output is high and the offered vector is below 32. For example, base 8 with line 5 gives vector 13 with the flag set.
- R8: An acknowledge while pending is high clears only the request that was on offer. Other captured requests remain.
- R9: While the global enable is low, pending and overlap stay low but new requests are still captured. They appear once the enable returns high.
- R10: An acknowledge while pending is low has no effect on the captured requests.
- R11: A base write in the same cycle as an acknowledge clears the request that was offered under the old base. The next request is then offered with the new base.
- R12: A new rising edge on the line being acknowledged in the same cycle leaves that line captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 8 | Interrupt request lines; bit 0 is the timer tick |
| intEnable | input | 1 | Global enable for the pending output |
| baseWrEn | input | 1 | Load strobe for the base register |
| baseWrData | input | 8 | New base offset |
| intAck | input | 1 | One-cycle acknowledge from the CPU |
| intPending | output | 1 | A request is on offer |
| intVector | output | 8 | Vector of the request on offer |
| vecOverlap | output | 1 | Offered vector lies in the reserved exception range |

## Verification
Two collisions are provoked on purpose. The first is an acknowledge in the same cycle as a base write. It is judged by the vector that follows, which must be the next line's index added to the new base. The second is an acknowledge in the same cycle as a fresh rising edge on the line being taken. It is judged by pending staying high with that line's vector still on offer. Around these collisions the bench sweeps every request mask for draining order, and every line under several bases, including bases that wrap past 255 and bases inside the reserved range. The expected vector and overlap flag are computed arithmetically.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ackFire;
    logic loadBase;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] req,
  output logic [NUM_LINES-1:0] grantOh,
  output logic [IDX_W-1:0]     grantIdx,
  output logic                 anyReq
);
  // lower-index lines mask all higher ones
  logic [NUM_LINES-1:0] blockedBelow;

  assign blockedBelow[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < NUM_LINES; g++) begin : gChain
      assign blockedBelow[g] = blockedBelow[g-1] | req[g-1];
    end
  endgenerate

  assign grantOh = req & ~blockedBelow;
  assign anyReq  = |req;

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (grantOh[i]) grantIdx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_map_ctrl.sv
module irq_map_ctrl
  import irq_map_pkg::*;
(
  input  logic        intEnable,
  input  logic        intAck,
  input  logic        baseWrEn,
  input  logic        anyLatched,
  input  logic        overlapRaw,
  output ctrlStrobe_t strobes,
  output logic        intPending,
  output logic        vecOverlap
);
  logic visible;

  assign visible    = intEnable & anyLatched;
  assign intPending = visible;
  assign vecOverlap = visible & overlapRaw;

  always_comb begin
    strobes          = '0;
    strobes.ackFire  = intAck & visible;
    strobes.loadBase = baseWrEn;
  end
endmodule

// File: rtl/irq_map_dp.sv
module irq_map_dp
  import irq_map_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter int VEC_W        = 8,
  parameter int RESERVED_TOP = 32,
  parameter int BASE_RESET   = 32,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [VEC_W-1:0]     baseWrData,
  input  ctrlStrobe_t          strobes,
  output logic                 anyLatched,
  output logic                 overlapRaw,
  output logic [VEC_W-1:0]     intVector,
  output logic [VEC_W-1:0]     baseReg,
  output logic [NUM_LINES-1:0] latchedQ
);
  logic [NUM_LINES-1:0] prevLines;
  logic [NUM_LINES-1:0] riseMask;
  logic [NUM_LINES-1:0] clearMask;
  logic [NUM_LINES-1:0] grantOh;
  logic [IDX_W-1:0]     grantIdx;

  assign riseMask = irqLines & ~prevLines;

  irq_prio_enc #(.NUM_LINES(NUM_LINES)) u_enc (
    .req      (latchedQ),
    .grantOh  (grantOh),
    .grantIdx (grantIdx),
    .anyReq   (anyLatched)
  );

  assign clearMask = strobes.ackFire ? grantOh : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLines <= '0;
      latchedQ  <= '0;
      baseReg   <= VEC_W'(BASE_RESET);
    end else begin
      prevLines <= irqLines;
      // a fresh edge wins over the clear of the same line
      latchedQ  <= (latchedQ & ~clearMask) | riseMask;
      if (strobes.loadBase) baseReg <= baseWrData;
    end
  end

  assign intVector  = baseReg + VEC_W'(grantIdx);
  assign overlapRaw = (intVector < VEC_W'(RESERVED_TOP));
endmodule

// File: rtl/irq_vector_mapper.sv
module irq_vector_mapper
  import irq_map_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter int VEC_W        = 8,
  parameter int RESERVED_TOP = 32,
  parameter int BASE_RESET   = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 intEnable,
  input  logic                 baseWrEn,
  input  logic [VEC_W-1:0]     baseWrData,
  input  logic                 intAck,
  output logic                 intPending,
  output logic [VEC_W-1:0]     intVector,
  output logic                 vecOverlap
);
  ctrlStrobe_t          strobes;
  logic                 anyLatched;
  logic                 overlapRaw;
  logic [VEC_W-1:0]     baseReg;
  logic [NUM_LINES-1:0] latchedQ;

  irq_map_ctrl u_ctrl (
    .intEnable  (intEnable),
    .intAck     (intAck),
    .baseWrEn   (baseWrEn),
    .anyLatched (anyLatched),
    .overlapRaw (overlapRaw),
    .strobes    (strobes),
    .intPending (intPending),
    .vecOverlap (vecOverlap)
  );

  irq_map_dp #(
    .NUM_LINES    (NUM_LINES),
    .VEC_W        (VEC_W),
    .RESERVED_TOP (RESERVED_TOP),
    .BASE_RESET   (BASE_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .irqLines   (irqLines),
    .baseWrData (baseWrData),
    .strobes    (strobes),
    .anyLatched (anyLatched),
    .overlapRaw (overlapRaw),
    .intVector  (intVector),
    .baseReg    (baseReg),
    .latchedQ   (latchedQ)
  );
endmodule

// File: rtl/irq_vector_mapper_chk.sv
module irq_vector_mapper_chk #(
  parameter int NUM_LINES    = 8,
  parameter int VEC_W        = 8,
  parameter int RESERVED_TOP = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 intEnable,
  input logic                 baseWrEn,
  input logic [VEC_W-1:0]     baseWrData,
  input logic                 intAck,
  input logic                 intPending,
  input logic [VEC_W-1:0]     intVector,
  input logic                 vecOverlap,
  input logic [VEC_W-1:0]     baseReg,
  input logic [NUM_LINES-1:0] latchedQ
);
  logic [VEC_W-1:0] offset;
  assign offset = intVector - baseReg;

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> (!intPending && !vecOverlap)); // R9

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |=> (baseReg == $past(baseWrData))); // R6

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ((|latchedQ) && !(intAck && intPending)) |=> (|latchedQ)); // R3

  AST_OVERLAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    vecOverlap |-> (intPending && (intVector < VEC_W'(RESERVED_TOP)))); // R7

  AST_VECTOR_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    intPending |-> (offset < VEC_W'(NUM_LINES))); // R5

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intPending) |=> ($countones(latchedQ) >= $countones($past(latchedQ)))); // R10
endmodule

bind irq_vector_mapper irq_vector_mapper_chk #(
  .NUM_LINES    (NUM_LINES),
  .VEC_W        (VEC_W),
  .RESERVED_TOP (RESERVED_TOP)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .intEnable  (intEnable),
  .baseWrEn   (baseWrEn),
  .baseWrData (baseWrData),
  .intAck     (intAck),
  .intPending (intPending),
  .intVector  (intVector),
  .vecOverlap (vecOverlap),
  .baseReg    (baseReg),
  .latchedQ   (latchedQ)
);

// File: tb/irq_vector_mapper_bench.sv
module irq_vector_mapper_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] irqLines;
  logic       intEnable;
  logic       baseWrEn;
  logic [7:0] baseWrData;
  logic       intAck;
  logic       intPending;
  logic [7:0] intVector;
  logic       vecOverlap;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_mapper u_irq_vector_mapper (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .intEnable(intEnable),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData), .intAck(intAck),
    .intPending(intPending), .intVector(intVector), .vecOverlap(vecOverlap)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outputs for one offered line
  task automatic expectLine(input string req, input int base, input int line);
    int v;
    v = (base + line) % 256;
    check({req, " pending"}, int'(intPending), 1);
    check({req, " vector"}, int'(intVector), v);
    check({req, " overlap"}, int'(vecOverlap), (v < 32) ? 1 : 0);
  endtask

  task automatic writeBase(input int b);
    baseWrEn = 1'b1; baseWrData = 8'(b);
    step();
    baseWrEn = 1'b0;
  endtask

  task automatic ackOnce();
    intAck = 1'b1;
    step();
    intAck = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int bases[8];
    bases = '{0, 8, 24, 31, 32, 100, 250, 255};
    rstN = 1'b0; irqLines = '0; intEnable = 1'b1; baseWrEn = 1'b0;
    baseWrData = '0; intAck = 1'b0;
    step(); step();
    rstN = 1'b1;
    check("R1 reset pending", int'(intPending), 0);
    check("R1 reset overlap", int'(vecOverlap), 0);

    // R1: default base 32 seen through line 0
    irqLines = 8'h01; step();
    expectLine("R1 default base", 32, 0);
    ackOnce();
    check("R2 held line no relatch", int'(intPending), 0);
    irqLines = '0; step();

    // R5 R6 R7 R2: every line under several bases
    foreach (bases[k]) begin
      writeBase(bases[k]);
      for (int l = 0; l < 8; l++) begin
        irqLines = 8'(1 << l); step();
        expectLine("R5 R6 R7 sweep", bases[k], l);
        ackOnce();
        check("R2 R8 sweep cleared", int'(intPending), 0);
        irqLines = '0; step();
      end
    end

    // R7: legacy alias, base 8 line 5 -> 13
    writeBase(8);
    irqLines = 8'h20; step(); irqLines = '0; step();
    check("R7 alias vector", int'(intVector), 13);
    check("R7 alias overlap", int'(vecOverlap), 1);
    ackOnce();

    // R4 R3 R8: every mask drains lowest-first
    writeBase(32);
    for (int m = 1; m < 256; m++) begin
      int rem;
      rem = m;
      irqLines = 8'(m); step();
      irqLines = '0; step();
      while (rem != 0) begin
        int low;
        low = 0;
        while (((rem >> low) & 1) == 0) low++;
        check("R4 R3 priority vector", int'(intVector), 32 + low);
        check("R4 pending", int'(intPending), 1);
        ackOnce();
        rem = rem & ~(1 << low);
      end
      check("R8 mask drained", int'(intPending), 0);
    end

    // R9 R10: disabled capture, acknowledge ignored
    writeBase(8);
    intEnable = 1'b0;
    irqLines = 8'h24; step(); irqLines = '0; step();
    check("R9 gated pending", int'(intPending), 0);
    check("R9 gated overlap", int'(vecOverlap), 0);
    ackOnce();
    intEnable = 1'b1; #1;
    expectLine("R9 R10 released line2", 8, 2);
    ackOnce();
    expectLine("R8 next line5", 8, 5);
    ackOnce();
    check("R8 drained", int'(intPending), 0);
    ackOnce();
    check("R10 idle ack", int'(intPending), 0);

    // R11: acknowledge and base write in one cycle
    writeBase(32);
    irqLines = 8'h03; step(); irqLines = '0; step();
    expectLine("R11 before", 32, 0);
    intAck = 1'b1; baseWrEn = 1'b1; baseWrData = 8'd64;
    step();
    intAck = 1'b0; baseWrEn = 1'b0;
    expectLine("R11 after", 64, 1);
    ackOnce();
    check("R11 drained", int'(intPending), 0);

    // R12: new edge on the line being acknowledged
    irqLines = 8'h08; step(); irqLines = '0; step();
    expectLine("R12 before", 64, 3);
    intAck = 1'b1; irqLines = 8'h08;
    step();
    intAck = 1'b0;
    expectLine("R12 kept", 64, 3);
    ackOnce();
    check("R12 then cleared", int'(intPending), 0);
    irqLines = '0; step();

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule